// File: doc/BRIEF.md
# Command-Driven UART Transmit Sequencer

This block is a UART transmitter under register control. Software loads a character count, fills a word-wide transmit queue, and writes a start opcode to the command word. The engine then takes one character from the queue at a time and drives it onto a serial line. The line rate comes from a programmable divider followed by a fixed 32-tick bit period. The transfer ends when the programmed number of characters has left the line. Software can also abort the transfer at any time.

Progress is reported through a 32-bit interrupt status word. Its bits record completion, abort, illegal commands, queue write errors and a low-queue watermark. Software clears each bit by writing a one to it. A mask register selects which status bits drive the single interrupt output.

Top module: `uart_tx_seq`

## Requirements
- R1: After reset the serial line is high, the status word (address 5) and the interrupt status (address 6) read 0, the queue count (address 10) reads 0 and the watermark register (address 3) reads 2.
- R2: Writing opcode 1 in bits 31:27 of the command word (address 0) while idle starts a transfer of the count held at address 2. Status bit 0 reads 1 while the transfer runs. When the last character has been sent, status bit 0 returns to 0 and interrupt status bit 0 (done) is set. A count of 0 sets done at once, with no activity on the line.
- R3: The line idles high. Each character is a low start bit, then 8 data bits LSB first, then the stop bits. Each bit lasts 32 times the divider in bits 15:4 of address 4 (a divider of 0 counts as 1), and bit 0 of address 4 enables the bit clock. Bit 0 of address 11 selects two stop bits; otherwise one stop bit is sent.
- R4: A command word with an opcode other than 1, or opcode 1 while a transfer is running, sets interrupt status bit 2. A running transfer continues unchanged.
- R5: Each write to address 10 pushes one word into a 16-entry queue, and bits 7:0 of the word are the character. Address 10 reads back the number of queued words. A write to a full queue is dropped and sets interrupt status bit 29.
- R6: Writing a 1 to bit 1 of the control register (address 1) ends the transfer on the next edge. The line returns high, status bit 0 clears, the queue is emptied and interrupt status bit 5 is set.
- R7: Interrupt status bit 30 is set in any cycle where a transfer is running and the queue count is at or below the watermark. It is never set while the engine is idle.
- R8: Writing a word to address 7 clears each interrupt status bit that is 1 in that word and leaves the other bits alone. Writing all ones clears every bit.
- R9: The irq output is high exactly when some interrupt status bit and the same bit of the enable register (address 8) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the addressed register (combinational) |
| irq | output | 1 | Masked interrupt request |
| txd | output | 1 | Serial transmit line |

## Verification
The bench keeps the default 16-word queue and uses small dividers (1, 2 and 3), so a bit lasts only 32 to 96 clocks. At that rate a single transfer can carry every one of the 256 character values in order. During that transfer the queue is refilled while it drains, so the watermark is crossed along the way. Runs with two stop bits and with a larger divider check the frame length. A 17-word burst and a mid-character abort reach the full-queue error and the flush.

// File: rtl/uart_tx_seq.sv
module uart_tx_seq #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 12,
  parameter int OVS    = 32,
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              txd
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int OVS_W = $clog2(OVS);

  localparam logic [ADDR_W-1:0] A_CMD = 0, A_CTRL = 1, A_LEN = 2, A_WM = 3,
    A_CLK = 4, A_STAT = 5, A_IRQ = 6, A_CLR = 7, A_IEN = 8, A_FIFO = 10, A_CFG = 11;
  localparam int B_DONE = 0, B_ILL = 2, B_ABORT = 5, B_WERR = 29, B_WM = 30;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wp, rp;
  logic [CNT_W-1:0]  cnt, wm_r;
  logic [LEN_W-1:0]  len_r, remain;
  logic [DIV_W-1:0]  div_r, divcnt;
  logic              clk_en, stop2, active, busy;
  logic [3:0]        bitpos;
  logic [OVS_W-1:0]  ovs;
  logic [7:0]        shreg;
  logic [31:0]       irq_stat, irq_en, set_m, clr_m;

  wire wr_cmd    = wr_en && addr == A_CMD;
  wire start_op  = wdata[31:27] == 5'd1;
  wire start_ok  = wr_cmd && start_op && !active;
  wire illegal   = wr_cmd && (!start_op || active);
  wire abort_req = wr_en && addr == A_CTRL && wdata[1];
  wire push_req  = wr_en && addr == A_FIFO;
  wire full      = cnt == CNT_W'(DEPTH);
  wire push      = push_req && !full && !abort_req;
  wire werr      = push_req && full;

  wire [DIV_W-1:0] div_eff = (div_r == '0) ? DIV_W'(1) : div_r;
  wire tick     = clk_en && divcnt == div_eff - DIV_W'(1);
  wire load     = active && !busy && remain != '0 && cnt != '0 && !abort_req;
  wire [3:0] last_pos = stop2 ? 4'd10 : 4'd9;
  wire bit_end  = busy && tick && ovs == OVS_W'(OVS - 1);
  wire char_end = bit_end && bitpos == last_pos;
  wire fin      = char_end && remain == LEN_W'(1);

  assign txd = !busy ? 1'b1 : (bitpos == 4'd0) ? 1'b0 : (bitpos <= 4'd8) ? shreg[0] : 1'b1;
  assign irq = |(irq_stat & irq_en);

  always_comb begin
    set_m = '0;
    set_m[B_DONE]  = fin || (start_ok && len_r == '0);
    set_m[B_ILL]   = illegal;
    set_m[B_ABORT] = abort_req;
    set_m[B_WERR]  = werr;
    set_m[B_WM]    = active && cnt <= wm_r;
    clr_m = (wr_en && addr == A_CLR) ? wdata : '0;
  end

  always_comb begin
    case (addr)
      A_LEN:   rdata = DATA_W'(len_r);
      A_WM:    rdata = DATA_W'(wm_r);
      A_CLK:   rdata = DATA_W'({div_r, 3'b000, clk_en});
      A_STAT:  rdata = DATA_W'(active);
      A_IRQ:   rdata = irq_stat;
      A_IEN:   rdata = irq_en;
      A_FIFO:  rdata = DATA_W'(cnt);
      A_CFG:   rdata = DATA_W'(stop2);
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_r <= '0; wm_r <= CNT_W'(2); div_r <= DIV_W'(1); clk_en <= 1'b0;
      stop2 <= 1'b0; irq_en <= '0; irq_stat <= '0;
    end else begin
      if (wr_en && addr == A_LEN) len_r <= wdata[LEN_W-1:0];
      if (wr_en && addr == A_WM)  wm_r <= wdata[CNT_W-1:0];
      if (wr_en && addr == A_CLK) begin
        clk_en <= wdata[0];
        div_r  <= wdata[4 +: DIV_W];
      end
      if (wr_en && addr == A_CFG) stop2 <= wdata[0];
      if (wr_en && addr == A_IEN) irq_en <= wdata;
      irq_stat <= (irq_stat & ~clr_m) | set_m;
    end
  end

  always_ff @(posedge clk) if (push) mem[wp] <= wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else if (abort_req) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (push) wp <= (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + PTR_W'(1);
      if (load) rp <= (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + PTR_W'(1);
      cnt <= cnt + CNT_W'(push) - CNT_W'(load);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; remain <= '0;
    end else if (abort_req) begin
      active <= 1'b0; remain <= '0;
    end else if (start_ok) begin
      active <= len_r != '0; remain <= len_r;
    end else if (char_end) begin
      remain <= remain - LEN_W'(1);
      if (fin) active <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) divcnt <= '0;
    else if (!clk_en || load || tick) divcnt <= '0;
    else divcnt <= divcnt + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; bitpos <= '0; ovs <= '0; shreg <= '0;
    end else if (abort_req) begin
      busy <= 1'b0; bitpos <= '0; ovs <= '0;
    end else if (load) begin
      busy <= 1'b1; bitpos <= '0; ovs <= '0; shreg <= mem[rp][7:0];
    end else if (busy && tick) begin
      ovs <= (ovs == OVS_W'(OVS - 1)) ? '0 : ovs + OVS_W'(1);
      if (bit_end) begin
        bitpos <= bitpos + 4'd1;
        if (bitpos >= 4'd1 && bitpos <= 4'd8) shreg <= {1'b0, shreg[7:1]};
        if (char_end) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_tx_seq_chk.sv
module uart_tx_seq_chk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [3:0]       addr,
  input logic [31:0]      wdata,
  input logic             active,
  input logic             txd,
  input logic [CNT_W-1:0] cnt,
  input logic [31:0]      irq_stat
);
  wire abort_w = wr_en && addr == 4'd1 && wdata[1];
  wire start_w = wr_en && addr == 4'd0 && wdata[31:27] == 5'd1;

  assert_idle_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> txd);
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));
  assert_abort_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    abort_w |=> (irq_stat[5] && !active && cnt == '0));
  assert_illegal_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_w && active) |=> irq_stat[2]);
  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_stat[0]) |-> !active);
  assert_wm_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_stat[30]) |-> $past(active));
endmodule

bind uart_tx_seq uart_tx_seq_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .active(active), .txd(txd), .cnt(cnt), .irq_stat(irq_stat));

// File: tb/uart_tx_seq_test.sv
`timescale 1ns/1ps
module uart_tx_seq_test;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [3:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic irq, txd;
  int n_chk = 0, n_bad = 0;

  uart_tx_seq uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .txd(txd));

  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; #0.1; d = rdata;
  endtask

  task automatic recv(input int bitc, input bit two, output logic [7:0] b, output bit stop_ok);
    stop_ok = 1;
    do @(negedge clk); while (txd);
    repeat (bitc / 2) @(negedge clk);
    if (txd) stop_ok = 0;
    for (int i = 0; i < 8; i++) begin
      repeat (bitc) @(negedge clk);
      b[i] = txd;
    end
    repeat (bitc) @(negedge clk);
    if (!txd) stop_ok = 0;
    if (two) begin
      repeat (bitc) @(negedge clk);
      if (!txd) stop_ok = 0;
    end
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int k = 0; k < 5000; k++) begin
      rd(4'd5, s);
      if (s[0] == 0) break;
      @(negedge clk);
    end
  endtask

  task automatic send_set(input int div, input bit two, input logic [7:0] pat[4], input bit dup);
    logic [7:0] b; bit ok; logic [31:0] s;
    wr(4'd4, (div << 4) | 1);
    wr(4'd11, two);
    wr(4'd7, 32'hFFFF_FFFF);
    wr(4'd2, 4);
    for (int i = 0; i < 4; i++) wr(4'd10, {24'h0, pat[i]});
    fork
      for (int i = 0; i < 4; i++) begin
        recv(32 * div, two, b, ok);
        check($sformatf("R3 char %0d div %0d", i, div), b, pat[i]);
        check("R3 stop bits", ok, 1);
      end
      begin
        wr(4'd0, 32'h0800_0000);
        if (dup) begin
          wr(4'd0, 32'h0800_0000);
          rd(4'd6, s); check("R4 start while active", s[2], 1);
          rd(4'd5, s); check("R4 still active", s[0], 1);
        end
      end
    join
    wait_idle();
    rd(4'd5, s); check("R2 idle after count", s[0], 0);
    rd(4'd6, s); check("R2 done set", s[0], 1);
  endtask

  initial begin
    #(190000 * 5);
    n_bad++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] s; logic [7:0] b; bit ok;
    logic [7:0] p1[4] = '{8'h55, 8'hAA, 8'h00, 8'hFF};
    logic [7:0] p2[4] = '{8'h01, 8'h80, 8'h3C, 8'hC3};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 txd idle", txd, 1);
    rd(4'd5, s); check("R1 status", s, 0);
    rd(4'd6, s); check("R1 irq status", s, 0);
    rd(4'd10, s); check("R1 count", s, 0);
    rd(4'd3, s); check("R1 watermark", s, 2);

    // Exhaustive character sweep, divider 1, one stop bit
    wr(4'd4, 32'h11);
    wr(4'd2, 256);
    wr(4'd0, 32'h0800_0000);
    rd(4'd5, s); check("R2 active", s[0], 1);
    fork
      for (int i = 0; i < 256; i++) begin
        recv(32, 0, b, ok);
        check($sformatf("R3 sweep char %0d", i), b, i[7:0]);
        check("R3 sweep stop", ok, 1);
      end
      for (int i = 0; i < 256; i++) begin
        do begin @(negedge clk); rd(4'd10, s); end while (s >= 16);
        wr(4'd10, 32'hABCD_0000 | i);
      end
    join
    wait_idle();
    rd(4'd5, s); check("R2 finished", s[0], 0);
    rd(4'd6, s); check("R2 done bit", s[0], 1);
    check("R7 watermark seen", s[30], 1);
    check("R9 irq masked off", irq, 0);
    wr(4'd8, 32'h1);
    @(negedge clk); check("R9 irq enabled", irq, 1);
    wr(4'd8, 32'h0);

    send_set(3, 1, p1, 1);
    send_set(2, 0, p2, 0);

    // Bad opcode and zero length
    wr(4'd7, 32'hFFFF_FFFF);
    wr(4'd0, 32'h1000_0000);
    rd(4'd6, s); check("R4 bad opcode", s[2], 1);
    rd(4'd5, s); check("R4 bad opcode idle", s[0], 0);
    wr(4'd7, 32'hFFFF_FFFF);
    rd(4'd6, s); check("R8 clear all", s, 0);
    wr(4'd2, 0);
    wr(4'd0, 32'h0800_0000);
    rd(4'd6, s); check("R2 zero length done", s[0], 1);
    rd(4'd5, s); check("R2 zero length idle", s[0], 0);
    check("R2 zero length line", txd, 1);

    // Full queue
    wr(4'd7, 32'hFFFF_FFFF);
    for (int i = 0; i < 17; i++) wr(4'd10, i);
    rd(4'd10, s); check("R5 count full", s, 16);
    rd(4'd6, s); check("R5 write error", s[29], 1);
    check("R7 no watermark idle", s[30], 0);

    // Abort mid character
    wr(4'd4, 32'h11);
    wr(4'd2, 16);
    wr(4'd0, 32'h0800_0000);
    repeat (150) @(negedge clk);
    wr(4'd1, 32'h2);
    check("R6 line high", txd, 1);
    rd(4'd5, s); check("R6 inactive", s[0], 0);
    rd(4'd10, s); check("R6 flushed", s, 0);
    rd(4'd6, s); check("R6 abort bit", s[5], 1);
    check("R6 no done", s[0], 0);
    wr(4'd7, 32'h20);
    rd(4'd6, s); check("R8 abort cleared", s[5], 0);
    check("R8 others kept", s[29], 1);
    wr(4'd7, 32'hFFFF_FFFF);
    rd(4'd6, s); check("R8 all cleared", s, 0);
    repeat (100) @(negedge clk);
    check("R6 line stays high", txd, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule